// File: doc/BRIEF.md
# Reset Cause Flag Register

This block keeps a sixteen-bit status word that tells firmware why the system last came out of reset or last went into a low-power state. Elsewhere on the chip, event detectors raise one-cycle pulses for these conditions: power-on, brown-out, the external reset pin, a software reset, a watchdog expiry, a trap conflict, an illegal opcode or uninitialized register access, and entry to sleep or idle. Each pulse sets its own flag. Some pulses also clear other flags. For example, a power-on pulse wipes the history flags and marks itself, and a brown-out clears most flags but leaves the external-pin and power-on marks alone.

Software reads the whole word. It can also write it to set or clear any implemented flag, usually to clear a flag after the cause has been handled. A hardware event wins over a write in the same cycle. When a set and a clear for the same bit arrive together, the set wins. All updates take effect on the next rising clock edge.

Top module: `reset_cause_reg`

## Requirements
- R1: While rst_ni is low, flags_o reads 16'h0000.
- R2: Each of these pulses sets its own bit: trap_i sets bit 15, illop_i sets bit 14, ext_rst_i sets bit 7, sw_rst_i sets bit 6, wdt_to_i sets bit 4, sleep_i sets bit 3, idle_i sets bit 2.
- R3: por_i sets bits 1 and 0, and clears bits 15, 14, 7, 6, 4, 3 and 2.
- R4: bor_i sets bit 1, clears bits 15, 14, 6, 4, 3 and 2, and leaves bits 7 and 0 unchanged.
- R5: sleep_i or idle_i clears bit 4.
- R6: If a set and a clear for the same bit arrive in the same cycle, the bit ends up set.
- R7: When we_i is high and no event touches a bit, that implemented bit takes its value from wdata_i.
- R8: For a bit that an event sets or clears, the event decides the bit's value and the write in the same cycle is ignored for that bit.
- R9: Bits 13:8 and bit 5 always read 0, and writes to them are ignored.
- R10: With no event and we_i low, flags_o keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| por_i | input | 1 | Power-on reset event pulse |
| bor_i | input | 1 | Brown-out reset event pulse |
| ext_rst_i | input | 1 | External reset pin event pulse |
| sw_rst_i | input | 1 | Software reset instruction pulse |
| wdt_to_i | input | 1 | Watchdog time-out pulse |
| trap_i | input | 1 | Trap conflict pulse |
| illop_i | input | 1 | Illegal opcode or uninitialized register access pulse |
| sleep_i | input | 1 | Sleep entry pulse |
| idle_i | input | 1 | Idle entry pulse |
| we_i | input | 1 | Software write strobe |
| wdata_i | input | 16 | Software write data |
| flags_o | output | 16 | Flag word |

## Verification
Two kinds of collision matter here. A hardware event can arrive in the same cycle as a software write. A set event and a clear event can target the same bit in one cycle, for example a watchdog expiry together with sleep entry, or a trap together with a power-on pulse. The bench loads a known word, then applies every one of the 512 combinations of the nine event pulses, each with a write of a different pattern and again without a write. It compares the next flag word with a model that applies the write first, then the clears, then the sets.

// File: rtl/rcf_pkg.sv
package rcf_pkg;
  localparam int unsigned FLAG_W = 16;

  localparam int unsigned B_TRAP  = 15;
  localparam int unsigned B_ILLOP = 14;
  localparam int unsigned B_EXT   = 7;
  localparam int unsigned B_SW    = 6;
  localparam int unsigned B_WDT   = 4;
  localparam int unsigned B_SLEEP = 3;
  localparam int unsigned B_IDLE  = 2;
  localparam int unsigned B_BOR   = 1;
  localparam int unsigned B_POR   = 0;

  localparam logic [FLAG_W-1:0] USED_MASK =
    (FLAG_W'(1) << B_TRAP)  | (FLAG_W'(1) << B_ILLOP) |
    (FLAG_W'(1) << B_EXT)   | (FLAG_W'(1) << B_SW)    |
    (FLAG_W'(1) << B_WDT)   | (FLAG_W'(1) << B_SLEEP) |
    (FLAG_W'(1) << B_IDLE)  | (FLAG_W'(1) << B_BOR)   |
    (FLAG_W'(1) << B_POR);

  typedef struct packed {
    logic por;
    logic bor;
    logic ext;
    logic sw;
    logic wdt;
    logic trap;
    logic illop;
    logic sleep;
    logic idle;
  } rcf_events_t;
endpackage

// File: rtl/rcf_event_map.sv
module rcf_event_map
  import rcf_pkg::*;
(
  input  rcf_events_t       ev_i,
  output logic [FLAG_W-1:0] set_o,
  output logic [FLAG_W-1:0] clr_o
);
  logic pwr_rst;
  logic pwr_save;

  assign pwr_rst  = ev_i.por | ev_i.bor;
  assign pwr_save = ev_i.sleep | ev_i.idle;

  always_comb begin
    set_o = '0;
    set_o[B_TRAP]  = ev_i.trap;
    set_o[B_ILLOP] = ev_i.illop;
    set_o[B_EXT]   = ev_i.ext;
    set_o[B_SW]    = ev_i.sw;
    set_o[B_WDT]   = ev_i.wdt;
    set_o[B_SLEEP] = ev_i.sleep;
    set_o[B_IDLE]  = ev_i.idle;
    set_o[B_BOR]   = pwr_rst;
    set_o[B_POR]   = ev_i.por;
  end

  // external-pin flag survives brown-out; power-on and brown-out flags have no hw clear
  always_comb begin
    clr_o = '0;
    clr_o[B_TRAP]  = pwr_rst;
    clr_o[B_ILLOP] = pwr_rst;
    clr_o[B_EXT]   = ev_i.por;
    clr_o[B_SW]    = pwr_rst;
    clr_o[B_WDT]   = pwr_rst | pwr_save;
    clr_o[B_SLEEP] = pwr_rst;
    clr_o[B_IDLE]  = pwr_rst;
  end
endmodule

// File: rtl/rcf_flag_cell.sv
module rcf_flag_cell #(
  parameter bit IMPLEMENTED = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic we_i,
  input  logic wd_i,
  output logic q_o
);
  if (IMPLEMENTED) begin : g_flop
    logic q_q;
    logic q_d;

    // priority: set, then clear, then software write
    always_comb begin
      q_d = q_q;
      if (we_i)       q_d = wd_i;
      if (clr_i)      q_d = 1'b0;
      if (set_i)      q_d = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_q <= 1'b0;
      else         q_q <= q_d;
    end

    assign q_o = q_q;
  end else begin : g_tie
    logic unused_in;
    assign unused_in = ^{clk_i, rst_ni, set_i, clr_i, we_i, wd_i};
    assign q_o = 1'b0;
  end
endmodule

// File: rtl/reset_cause_reg.sv
module reset_cause_reg
  import rcf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_i,
  input  logic              bor_i,
  input  logic              ext_rst_i,
  input  logic              sw_rst_i,
  input  logic              wdt_to_i,
  input  logic              trap_i,
  input  logic              illop_i,
  input  logic              sleep_i,
  input  logic              idle_i,
  input  logic              we_i,
  input  logic [FLAG_W-1:0] wdata_i,
  output logic [FLAG_W-1:0] flags_o
);
  rcf_events_t       ev;
  logic [FLAG_W-1:0] set_vec;
  logic [FLAG_W-1:0] clr_vec;

  assign ev = '{por: por_i, bor: bor_i, ext: ext_rst_i, sw: sw_rst_i,
                wdt: wdt_to_i, trap: trap_i, illop: illop_i,
                sleep: sleep_i, idle: idle_i};

  rcf_event_map u_map (
    .ev_i  (ev),
    .set_o (set_vec),
    .clr_o (clr_vec)
  );

  for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
    rcf_flag_cell #(.IMPLEMENTED(USED_MASK[i])) u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_vec[i]),
      .clr_i  (clr_vec[i]),
      .we_i   (we_i),
      .wd_i   (wdata_i[i]),
      .q_o    (flags_o[i])
    );
  end
endmodule

// File: rtl/rcf_checker.sv
module rcf_checker
  import rcf_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              por_i,
  input logic              bor_i,
  input logic              ext_rst_i,
  input logic              sw_rst_i,
  input logic              wdt_to_i,
  input logic              trap_i,
  input logic              illop_i,
  input logic              sleep_i,
  input logic              idle_i,
  input logic              we_i,
  input logic [FLAG_W-1:0] wdata_i,
  input logic [FLAG_W-1:0] flags_o
);
  logic any_ev;
  assign any_ev = por_i | bor_i | ext_rst_i | sw_rst_i | wdt_to_i |
                  trap_i | illop_i | sleep_i | idle_i;

  always_comb begin
    if (!rst_ni) AST_RESET_CLEAR: assert (flags_o == '0); // R1
  end

  AST_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o & ~USED_MASK) == '0); // R9

  AST_POR_MARKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> flags_o[B_POR] && flags_o[B_BOR]); // R3

  AST_BOR_KEEPS_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bor_i && !por_i && !ext_rst_i && !we_i) |=> $stable(flags_o[B_EXT])); // R4

  AST_SAVE_CLR_WDT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sleep_i || idle_i) && !wdt_to_i) |=> !flags_o[B_WDT]); // R5

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_i && (por_i || bor_i)) |=> flags_o[B_TRAP]); // R6

  AST_WRITE_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !any_ev) |=> flags_o == ($past(wdata_i) & USED_MASK)); // R7

  AST_EVENT_OVER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wdt_to_i) |=> flags_o[B_WDT]); // R8

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !any_ev) |=> $stable(flags_o)); // R10
endmodule

bind reset_cause_reg rcf_checker u_rcf_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .por_i     (por_i),
  .bor_i     (bor_i),
  .ext_rst_i (ext_rst_i),
  .sw_rst_i  (sw_rst_i),
  .wdt_to_i  (wdt_to_i),
  .trap_i    (trap_i),
  .illop_i   (illop_i),
  .sleep_i   (sleep_i),
  .idle_i    (idle_i),
  .we_i      (we_i),
  .wdata_i   (wdata_i),
  .flags_o   (flags_o)
);

// File: tb/tb_reset_cause_reg.sv
module tb_reset_cause_reg;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        por_i = 0, bor_i = 0, ext_rst_i = 0, sw_rst_i = 0, wdt_to_i = 0;
  logic        trap_i = 0, illop_i = 0, sleep_i = 0, idle_i = 0, we_i = 0;
  logic [15:0] wdata_i = '0;
  logic [15:0] flags_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [15:0] MASK = 16'hC0DF;

  always #4 clk_i = ~clk_i;

  reset_cause_reg dut (.*);

  // ev bit order: 0 por,1 bor,2 ext,3 sw,4 wdt,5 trap,6 illop,7 sleep,8 idle
  function automatic logic [15:0] model(input logic [15:0] q, input logic [8:0] ev,
                                        input logic we, input logic [15:0] wd);
    logic [15:0] n;
    n = we ? (wd & MASK) : q;
    if (ev[0])          n &= ~16'hC0DC;
    if (ev[1])          n &= ~16'hC05C;
    if (ev[7] | ev[8])  n &= ~16'h0010;
    if (ev[0]) n |= 16'h0003;
    if (ev[1]) n |= 16'h0002;
    if (ev[2]) n[7]  = 1'b1;
    if (ev[3]) n[6]  = 1'b1;
    if (ev[4]) n[4]  = 1'b1;
    if (ev[5]) n[15] = 1'b1;
    if (ev[6]) n[14] = 1'b1;
    if (ev[7]) n[3]  = 1'b1;
    if (ev[8]) n[2]  = 1'b1;
    return n;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [8:0] ev, input logic we, input logic [15:0] wd);
    {idle_i, sleep_i, illop_i, trap_i, wdt_to_i, sw_rst_i, ext_rst_i, bor_i, por_i} = ev;
    we_i = we;
    wdata_i = wd;
  endtask

  // apply at negedge, step one edge, leave at next negedge with inputs idle
  task automatic step(input logic [8:0] ev, input logic we, input logic [15:0] wd);
    drive(ev, we, wd);
    @(posedge clk_i);
    @(negedge clk_i);
    drive('0, 1'b0, '0);
  endtask

  task automatic load(input logic [15:0] v);
    step('0, 1'b1, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] pre;
    logic [15:0] wd;
    repeat (3) @(negedge clk_i);
    chk("R1", flags_o, 16'h0000);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 single set events from zero
    for (int e = 2; e < 9; e++) begin
      load(16'h0000);
      step(9'(1 << e), 1'b0, '0);
      chk("R2", flags_o, model(16'h0000, 9'(1 << e), 1'b0, '0));
    end

    // R3 / R4 from all-ones
    load(16'hFFFF);
    step(9'h001, 1'b0, '0);
    chk("R3", flags_o, 16'h0003);
    load(16'hFFFF);
    step(9'h002, 1'b0, '0);
    chk("R4", flags_o, 16'h0083);

    // R5 idle clears watchdog flag
    load(16'h0010);
    step(9'h100, 1'b0, '0);
    chk("R5", flags_o, 16'h0004);

    // R6 watchdog set against sleep clear
    load(16'h0000);
    step(9'h090, 1'b0, '0);
    chk("R6", flags_o, 16'h0018);

    // R7 write, R9 unused bits
    load(16'hFFFF);
    chk("R9", flags_o, MASK);
    load(16'h5A5A);
    chk("R7", flags_o, 16'h5A5A & MASK);

    // R8 write zero with trap: trap wins for bit 15 only
    load(16'h0000);
    step(9'h020, 1'b1, 16'h00C3);
    chk("R8", flags_o, 16'h80C3);

    // R10 hold
    load(16'h4045);
    step('0, 1'b0, '0);
    step('0, 1'b0, '0);
    chk("R10", flags_o, 16'h4045);

    // sweep: all event combos, with and without write, two start words
    for (int s = 0; s < 2; s++) begin
      pre = (s == 0) ? 16'hFFFF : 16'h4A12;
      for (int c = 0; c < 512; c++) begin
        for (int w = 0; w < 2; w++) begin
          wd = 16'(c * 16'h9E37) ^ 16'hA5C3;
          load(pre);
          step(9'(c), w[0], wd);
          if (c[0])       chk("R3 sweep", flags_o, model(pre & MASK, 9'(c), w[0], wd));
          else if (c[1])  chk("R4 sweep", flags_o, model(pre & MASK, 9'(c), w[0], wd));
          else if (w[0])  chk("R8 sweep", flags_o, model(pre & MASK, 9'(c), w[0], wd));
          else            chk("R6 sweep", flags_o, model(pre & MASK, 9'(c), w[0], wd));
        end
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule